// File: doc/BRIEF.md
# Wakeup Interrupt Polarity Normalizer

This block sits between a bank of peripheral wake sources and an interrupt controller that only understands rising edges and active-high levels. Every channel carries its own 3-bit trigger type. The block synchronises each wake input, inverts it when the trigger type calls for it, and turns it into either a level or single-cycle pulses. It then gates the result with a per-channel enable bit. Software programs the enable bits and the trigger types through a simple word-wide register port. Writes are registered and reads are combinational.

Each channel runs a small controller with three states:
- `CH_OFF`: the channel is disabled and its output is held low.
- `CH_TRACK`: the channel forwards detected events.
- `CH_BLANK`: a one-cycle state entered when the channel's trigger type is rewritten with a different value.

The transitions are named as follows:
- `arm` (OFF→TRACK): the enable bit is set.
- `disarm` (TRACK→OFF): the enable bit is cleared.
- `reconfig` (any→BLANK): a type write changes the stored code.
- `resume` (BLANK→TRACK, or BLANK→OFF when the channel is disabled).

The BLANK cycle swallows the artificial edge that a polarity change would otherwise produce while the pin itself stands still.

Top module: `wake_polarity_norm`

## Requirements
- R1: During and after reset, all enable bits and all trigger types read as zero, and every `irq_out` bit is low.
- R2: Enable bits are packed 32 per word. Channel c is bit c%32 of the word at byte address 0x10 + 4*(c/32). A write updates the whole word, and a read of the word returns the stored bits.
- R3: Channel c's trigger type is bits [2:0] of the word at byte address 0x110 + 4*c. A read returns the stored 3 bits with bits [31:3] zero, whatever was written to those upper bits.
- R4: With type 110 (rising), a 0→1 change of the wake input produces a pulse on `irq_out` exactly one cycle wide. If the change is first sampled at clock edge E0, the output register is high after edge E0+2. A 1→0 change produces no pulse.
- R5: With type 010 (falling), the input is inverted before detection. A 1→0 change produces a one-cycle pulse with the R4 timing, and a 0→1 change produces none.
- R6: With type 111 (either edge), every transition of the input, in either direction, produces a one-cycle pulse with the R4 timing.
- R7: Type 100 makes the output follow the synchronised input as a level. Type 000 makes it follow the inverted input. The unlisted codes 001, 011 and 101 behave like 100. The latency is the same as in R4.
- R8: A channel whose enable bit is clear keeps its output low whatever its input does. If the enable is cleared by a write taking effect at edge W, the output is low after W+1. If the enable is set at W, the output can first be high after W+2. Writing one channel's enable bit leaves the other channels' outputs unaffected.
- R9: A type write that changes the stored code and takes effect at edge W forces that channel's output low after W+1. No pulse results from the change of polarity itself, and the new type governs detection afterwards. A write of an identical code causes no blanking.
- R10: A write to a byte address outside both register regions, or to a misaligned address (address bits [1:0] non-zero), changes no state. A read of such an address returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wake_in | input | NUM_CH | Asynchronous wake request inputs, one per channel |
| reg_wr | input | 1 | Register write strobe, sampled at the rising clock edge |
| reg_addr | input | ADDR_W | Byte address for reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq_out | output | NUM_CH | Normalised active-high / rising-edge requests to the interrupt controller |

## Verification
The bench builds the block with NUM_CH = 64 and ADDR_W = 12. At that size there are two enable words. This brings the second word (channel 40) within reach, and it puts the upper end of both regions just inside the address space. As a result, writes to the first enable word past the last channel, and to the first type address past the last channel, are real unmapped accesses whose lack of effect the bench can observe. With 64 channels the bench can also pair several trigger types with idle, disabled neighbours in one run. This shows that blanking, gating and detection stay local to each channel.

// File: rtl/wpn_pkg.sv
package wpn_pkg;

    localparam int unsigned EN_BASE   = 32'h0000_0010;
    localparam int unsigned TYPE_BASE = 32'h0000_0110;
    localparam int unsigned WORD_BITS = 32;
    localparam int unsigned TRIG_BITS = 3;

    // Trigger codes; any other value acts as an active-high level.
    typedef enum logic [2:0] {
        TRIG_LVL_LOW  = 3'b000,
        TRIG_FALL     = 3'b010,
        TRIG_LVL_HIGH = 3'b100,
        TRIG_RISE     = 3'b110,
        TRIG_BOTH     = 3'b111
    } trig_e;

    typedef enum logic [1:0] {
        DET_LEVEL = 2'd0,
        DET_RISE  = 2'd1,
        DET_BOTH  = 2'd2
    } det_e;

    typedef struct packed {
        logic invert;
        det_e det;
    } trig_cfg_t;

    typedef enum logic [1:0] {
        CH_OFF   = 2'd0,
        CH_TRACK = 2'd1,
        CH_BLANK = 2'd2
    } ch_state_e;

    function automatic trig_cfg_t decode_trig(input logic [2:0] code);
        trig_cfg_t cfg;
        unique case (trig_e'(code))
            TRIG_LVL_LOW:  begin cfg.invert = 1'b1; cfg.det = DET_LEVEL; end
            TRIG_FALL:     begin cfg.invert = 1'b1; cfg.det = DET_RISE;  end
            TRIG_RISE:     begin cfg.invert = 1'b0; cfg.det = DET_RISE;  end
            TRIG_BOTH:     begin cfg.invert = 1'b0; cfg.det = DET_BOTH;  end
            TRIG_LVL_HIGH: begin cfg.invert = 1'b0; cfg.det = DET_LEVEL; end
            default:       begin cfg.invert = 1'b0; cfg.det = DET_LEVEL; end
        endcase
        return cfg;
    endfunction

endpackage

// File: rtl/wpn_sync.sv
module wpn_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
        end else begin
            stage_q[0] <= async_in;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/wpn_regs.sv
module wpn_regs
    import wpn_pkg::*;
#(
    parameter int NUM_CH = 256,
    parameter int ADDR_W = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_wr,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic [31:0]           reg_wdata,
    output logic [31:0]           reg_rdata,
    output logic [NUM_CH-1:0]     en_vec,
    output logic [3*NUM_CH-1:0]   type_flat,
    output logic [NUM_CH-1:0]     type_chg
);

    localparam int NUM_WORDS = (NUM_CH + WORD_BITS - 1) / WORD_BITS;
    localparam int WD_W      = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
    localparam int CH_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam int unsigned EN_END   = EN_BASE + 4 * NUM_WORDS;
    localparam int unsigned TYPE_END = TYPE_BASE + 4 * NUM_CH;
    localparam int EN_BITS   = NUM_WORDS * WORD_BITS;

    function automatic logic [EN_BITS-1:0] valid_bits();
        logic [EN_BITS-1:0] v;
        for (int i = 0; i < EN_BITS; i++) v[i] = (i < NUM_CH);
        return v;
    endfunction

    localparam logic [EN_BITS-1:0] VALID = valid_bits();

    logic [31:0]         addr_x;
    logic                aligned;
    logic                en_hit;
    logic                ty_hit;
    logic [WD_W-1:0]     w_idx;
    logic [CH_W-1:0]     t_idx;
    logic [EN_BITS-1:0]  en_q;
    logic [2:0]          type_q [NUM_CH];

    // Address decode
    always_comb begin
        addr_x  = 32'(reg_addr);
        aligned = (reg_addr[1:0] == 2'b00);
        en_hit  = aligned && (addr_x >= EN_BASE) && (addr_x < EN_END);
        ty_hit  = aligned && (addr_x >= TYPE_BASE) && (addr_x < TYPE_END);
        w_idx   = WD_W'((addr_x - EN_BASE) >> 2);
        t_idx   = CH_W'((addr_x - TYPE_BASE) >> 2);
    end

    // Storage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= '0;
            for (int c = 0; c < NUM_CH; c++) type_q[c] <= '0;
        end else if (reg_wr) begin
            if (en_hit) begin
                en_q[w_idx*WORD_BITS +: WORD_BITS] <=
                    reg_wdata & VALID[w_idx*WORD_BITS +: WORD_BITS];
            end
            if (ty_hit) begin
                type_q[t_idx] <= reg_wdata[2:0];
            end
        end
    end

    // Read mux
    always_comb begin
        reg_rdata = '0;
        if (en_hit) begin
            reg_rdata = en_q[w_idx*WORD_BITS +: WORD_BITS];
        end else if (ty_hit) begin
            reg_rdata = {29'b0, type_q[t_idx]};
        end
    end

    assign en_vec = en_q[NUM_CH-1:0];

    // Per-channel views and change strobes
    for (genvar c = 0; c < NUM_CH; c++) begin : g_view
        assign type_flat[3*c +: 3] = type_q[c];
        assign type_chg[c] = reg_wr && ty_hit && (t_idx == CH_W'(c)) &&
                             (reg_wdata[2:0] != type_q[c]);
    end

endmodule

// File: rtl/wpn_chan.sv
module wpn_chan
    import wpn_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sample,
    input  logic [2:0] trig,
    input  logic       enable,
    input  logic       reconfig,
    output logic       irq
);

    trig_cfg_t cfg;
    logic      corr;
    logic      prev_q;
    logic      hit;
    logic      irq_q;
    ch_state_e state_q;
    ch_state_e state_d;

    assign cfg  = decode_trig(trig);
    assign corr = sample ^ cfg.invert;

    always_comb begin
        unique case (cfg.det)
            DET_LEVEL: hit = corr;
            DET_RISE:  hit = corr & ~prev_q;
            DET_BOTH:  hit = corr ^ prev_q;
            default:   hit = 1'b0;
        endcase
    end

    // Next-state logic
    always_comb begin
        unique case (state_q)
            CH_OFF:   state_d = reconfig ? CH_BLANK : (enable ? CH_TRACK : CH_OFF);
            CH_TRACK: state_d = reconfig ? CH_BLANK : (enable ? CH_TRACK : CH_OFF);
            CH_BLANK: state_d = reconfig ? CH_BLANK : (enable ? CH_TRACK : CH_OFF);
            default:  state_d = CH_OFF;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_OFF;
        else        state_q <= state_d;
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            prev_q <= corr;
            irq_q  <= (state_q == CH_TRACK) && enable && hit;
        end
    end

    assign irq = irq_q;

endmodule

// File: rtl/wake_polarity_norm.sv
module wake_polarity_norm
    import wpn_pkg::*;
#(
    parameter int NUM_CH      = 256,
    parameter int ADDR_W      = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] wake_in,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic [NUM_CH-1:0] irq_out
);

    logic [NUM_CH-1:0]   en_vec;
    logic [3*NUM_CH-1:0] type_flat;
    logic [NUM_CH-1:0]   type_chg;
    logic [NUM_CH-1:0]   wake_s;

    wpn_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .en_vec    (en_vec),
        .type_flat (type_flat),
        .type_chg  (type_chg)
    );

    wpn_sync #(.WIDTH(NUM_CH), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (wake_in),
        .sync_out (wake_s)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        wpn_chan u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .sample   (wake_s[c]),
            .trig     (type_flat[3*c +: 3]),
            .enable   (en_vec[c]),
            .reconfig (type_chg[c]),
            .irq      (irq_out[c])
        );
    end

endmodule

// File: rtl/wake_polarity_norm_chk.sv
module wake_polarity_norm_chk
    import wpn_pkg::*;
#(
    parameter int NUM_CH = 256,
    parameter int ADDR_W = 12
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NUM_CH-1:0]   irq_out,
    input logic [NUM_CH-1:0]   en_vec,
    input logic [3*NUM_CH-1:0] type_flat,
    input logic [NUM_CH-1:0]   type_chg,
    input logic [ADDR_W-1:0]   reg_addr,
    input logic [31:0]         reg_rdata
);

    localparam int unsigned TYPE_END = TYPE_BASE + 4 * NUM_CH;

    logic [NUM_CH-1:0] rise_mask;
    logic              ty_read;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_mask
        assign rise_mask[c] = (type_flat[3*c +: 3] == 3'b110) ||
                              (type_flat[3*c +: 3] == 3'b010);
    end

    assign ty_read = (reg_addr[1:0] == 2'b00) &&
                     (32'(reg_addr) >= TYPE_BASE) && (32'(reg_addr) < TYPE_END);

    // R1: outputs stay low while reset is held
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |-> (irq_out == '0));

    // R3: type reads carry only three significant bits
    p_type_upper_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ty_read |-> (reg_rdata[31:3] == '0));

    // R4: rising-edge channels never emit back-to-back pulses
    p_edge_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_out & $past(irq_out) & rise_mask & $past(rise_mask)) == '0));

    // R8: a channel disabled in the previous cycle shows no output
    p_disabled_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_out & ~$past(en_vec)) == '0));

    // R9: a changed type blanks the channel output one cycle later
    p_reconfig_blank_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (|type_chg) |-> ##2 ((irq_out & $past(type_chg, 2)) == '0));

endmodule

bind wake_polarity_norm wake_polarity_norm_chk #(
    .NUM_CH (NUM_CH),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_out   (irq_out),
    .en_vec    (en_vec),
    .type_flat (type_flat),
    .type_chg  (type_chg),
    .reg_addr  (reg_addr),
    .reg_rdata (reg_rdata)
);

// File: tb/wake_polarity_norm_test.sv
module wake_polarity_norm_test;

    localparam int CLK_PERIOD = 10;
    localparam int NCH        = 64;
    localparam int AW         = 12;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NCH-1:0]  wake_in = '0;
    logic            reg_wr = 1'b0;
    logic [AW-1:0]   reg_addr = '0;
    logic [31:0]     reg_wdata = '0;
    logic [31:0]     reg_rdata;
    logic [NCH-1:0]  irq_out;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    int k     = 0;
    bit done  = 0;

    typedef struct {
        int    at;
        int    ch;
        logic  val;
        string req;
    } exp_t;

    exp_t sb[$];

    wake_polarity_norm #(.NUM_CH(NCH), .ADDR_W(AW)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wake_in   (wake_in),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_out   (irq_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic expect_bit(input int ch, input int at, input logic val, input string req);
        exp_t e;
        e.at = at; e.ch = ch; e.val = val; e.req = req;
        sb.push_back(e);
    endtask

    task automatic expect_pulse(input int ch, input int k0, input string req);
        expect_bit(ch, k0 + 2, 1'b0, req);
        expect_bit(ch, k0 + 3, 1'b1, req);
        expect_bit(ch, k0 + 4, 1'b0, req);
    endtask

    task automatic expect_quiet(input int ch, input int k0, input string req);
        expect_bit(ch, k0 + 2, 1'b0, req);
        expect_bit(ch, k0 + 3, 1'b0, req);
        expect_bit(ch, k0 + 4, 1'b0, req);
    endtask

    // Drives a write; k holds the cycle in which it was presented.
    task automatic reg_write(input logic [AW-1:0] a, input logic [31:0] d);
        step();
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        k = cyc;
        step();
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [AW-1:0] a, input logic [31:0] exp, input string req);
        step();
        reg_addr = a;
        #2;
        chk(reg_rdata == exp, req, 64'(reg_rdata), 64'(exp));
    endtask

    task automatic toggle(input int ch, input logic v);
        step();
        wake_in[ch] = v;
        k = cyc;
    endtask

    // Monitor: compare scheduled expectations away from the clock edge
    always @(negedge clk) begin
        for (int i = sb.size() - 1; i >= 0; i--) begin
            if (sb[i].at == cyc) begin
                chk(irq_out[sb[i].ch] == sb[i].val, sb[i].req,
                    64'(irq_out[sb[i].ch]), 64'(sb[i].val));
                sb.delete(i);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        wake_in[1] = 1'b1;
        wake_in[4] = 1'b1;
        repeat (3) step();
        chk(irq_out == '0, "R1 outputs in reset", 64'(irq_out), 64'h0);
        rst_n = 1'b1;
        repeat (2) step();
        chk(irq_out == '0, "R1 outputs after reset", 64'(irq_out), 64'h0);
        reg_read(12'h010, 32'h0, "R1 enable word0");
        reg_read(12'h014, 32'h0, "R1 enable word1");
        reg_read(12'h114, 32'h0, "R1 type ch1");

        // Configure channels 0..6
        reg_write(12'h110, 32'h6);   // ch0 rising
        reg_write(12'h114, 32'h2);   // ch1 falling
        reg_write(12'h118, 32'h6);   // ch2 rising
        reg_write(12'h11C, 32'h7);   // ch3 both
        reg_write(12'h120, 32'h0);   // ch4 level low
        reg_write(12'h124, 32'h4);   // ch5 level high
        reg_write(12'h128, 32'h5);   // ch6 unlisted
        reg_write(12'h010, 32'h7F);
        reg_read(12'h010, 32'h7F, "R2 enable word0 readback");
        reg_read(12'h110, 32'h6, "R3 type ch0 readback");
        reg_read(12'h128, 32'h5, "R3 type ch6 readback");
        repeat (6) step();
        chk(irq_out == '0, "R7 idle levels inactive", 64'(irq_out), 64'h0);

        // R4 rising
        toggle(0, 1'b1); expect_pulse(0, k, "R4 rise pulse");
        repeat (6) step();
        toggle(0, 1'b0); expect_quiet(0, k, "R4 fall ignored");
        repeat (6) step();

        // R5 falling
        toggle(1, 1'b0); expect_pulse(1, k, "R5 fall pulse");
        repeat (6) step();
        toggle(1, 1'b1); expect_quiet(1, k, "R5 rise ignored");
        repeat (6) step();

        // R6 both edges
        toggle(3, 1'b1); expect_pulse(3, k, "R6 rise pulse");
        repeat (6) step();
        toggle(3, 1'b0); expect_pulse(3, k, "R6 fall pulse");
        repeat (6) step();

        // R7 levels
        toggle(5, 1'b1);
        expect_bit(5, k + 2, 1'b0, "R7 high level latency");
        expect_bit(5, k + 3, 1'b1, "R7 high level asserts");
        expect_bit(5, k + 6, 1'b1, "R7 high level holds");
        repeat (8) step();
        toggle(4, 1'b0);
        expect_bit(4, k + 3, 1'b1, "R7 low level asserts");
        expect_bit(4, k + 6, 1'b1, "R7 low level holds");
        repeat (8) step();
        toggle(6, 1'b1);
        expect_bit(6, k + 3, 1'b1, "R7 unlisted code acts high");
        repeat (8) step();

        // R8 enable gating
        reg_write(12'h010, 32'h5F);
        expect_bit(5, k + 1, 1'b1, "R8 before disable");
        expect_bit(5, k + 2, 1'b0, "R8 disabled output low");
        expect_bit(5, k + 5, 1'b0, "R8 stays low");
        expect_bit(4, k + 2, 1'b1, "R8 neighbour unaffected");
        repeat (8) step();
        chk(irq_out[8] == 1'b0, "R8 never-enabled channel", 64'(irq_out[8]), 64'h0);
        reg_write(12'h010, 32'h7F);
        expect_bit(5, k + 2, 1'b0, "R8 enable arming cycle");
        expect_bit(5, k + 3, 1'b1, "R8 re-enabled level");
        repeat (8) step();

        // R9 reconfiguration blanking
        reg_write(12'h118, 32'h2);   // ch2 rising -> falling, input low
        expect_bit(2, k + 1, 1'b0, "R9 blank");
        expect_bit(2, k + 2, 1'b0, "R9 blank");
        expect_bit(2, k + 3, 1'b0, "R9 blank");
        expect_bit(2, k + 4, 1'b0, "R9 blank");
        repeat (6) step();
        toggle(2, 1'b1); expect_quiet(2, k, "R9 new type ignores rise");
        repeat (6) step();
        toggle(2, 1'b0); expect_pulse(2, k, "R9 new type falling pulse");
        repeat (6) step();
        reg_write(12'h128, 32'h4);   // ch6 101 -> 100, input high
        expect_bit(6, k + 1, 1'b1, "R9 level before blank");
        expect_bit(6, k + 2, 1'b0, "R9 level blanked");
        expect_bit(6, k + 3, 1'b1, "R9 level resumes");
        repeat (6) step();
        reg_write(12'h128, 32'h4);   // same code
        expect_bit(6, k + 2, 1'b1, "R9 same code no blank");
        repeat (6) step();

        // R2 second enable word
        reg_write(12'h1B0, 32'h6);   // ch40 rising
        reg_write(12'h014, 32'h100);
        reg_read(12'h014, 32'h100, "R2 enable word1 readback");
        repeat (4) step();
        toggle(40, 1'b1); expect_pulse(40, k, "R2 ch40 in word1");
        repeat (6) step();

        // R3 upper bits dropped
        reg_write(12'h12C, 32'hFFFF_FFF9);
        reg_read(12'h12C, 32'h1, "R3 upper bits read zero");

        // R10 unmapped and misaligned writes
        reg_write(12'h018, 32'hFFFF_FFFF);
        reg_write(12'h210, 32'h7);
        reg_write(12'h111, 32'h7);
        reg_write(12'h000, 32'hFFFF_FFFF);
        reg_read(12'h010, 32'h7F, "R10 enable word0 unchanged");
        reg_read(12'h014, 32'h100, "R10 enable word1 unchanged");
        reg_read(12'h110, 32'h6, "R10 type ch0 unchanged");
        reg_read(12'h210, 32'h0, "R10 unmapped type read");
        reg_read(12'h018, 32'h0, "R10 unmapped enable read");
        reg_read(12'h111, 32'h0, "R10 misaligned read");
        repeat (4) step();
        chk((irq_out & 64'hFFFF_FFFF_FFFF_FF80) == '0, "R10 no stray outputs",
            64'(irq_out), 64'(irq_out & 64'h7F));

        repeat (8) step();
        chk(sb.size() == 0, "R4 scoreboard drained", 64'(sb.size()), 64'h0);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule